// File: doc/BRIEF.md
# Timecode Line Deframer with Check Byte

This block takes the serial bits of one vertical-interval timecode line. The bits are already sliced and clocked, and each one arrives as a single-bit beat on a valid/ready stream. A start-of-line pulse marks where each line begins. One line holds 90 framed bits, split into nine groups of ten. The two lowest-numbered bits of each group are sync bits. The block drops them and packs the remaining eight data bits of every group into nine byte slots. The last slot holds the check byte sent with the line.

While it packs, the block also runs an 8-bit check over the raw framed stream. This check includes the sync bits that the packer throws away. When the 90th bit of a line is accepted, the nine slots, the computed check value and a match flag all change together, and a sticky available flag rises.

A one-cycle clear pulse returns every readback output to zero. The input stream never applies back-pressure: in_ready is always high, and a beat counts in every cycle where in_valid is high.

Top module: `tc_line_deframer`

## Requirements
- R1: Framed bit n of a line sits in group n/10 at offset n%10. Offsets 0 and 1 are sync bits and are never stored. Slot k (slots_o[8k+7:8k]) holds framed bits 10k+9 down to 10k+2, and the lower-numbered bit goes to the slot's bit 0.
- R2: crc_o is the state of an 8-bit shift register (polynomial x^8+1) fed with framed bits 0 to 81, sync bits included. Bit j of crc_o equals the XOR of every framed bit i in 0..81 with (81-i) mod 8 == j.
- R3: crc_ok_o is 1 exactly when crc_o equals slot 8, the received check byte. It is 0 while avail_o is 0.
- R4: slots_o, crc_o and crc_ok_o change only on the clock edge that accepts the 90th bit of a line. On that same edge avail_o goes to 1, and it stays 1 until a clear.
- R5: After reset, avail_o, crc_ok_o, crc_o and slots_o are all 0.
- R6: A cycle with clr_i high makes all readback outputs 0 on the next edge. If that cycle also completes a line, the clear wins.
- R7: sol_i starts a new line. A beat accepted in the same cycle as sol_i is bit 0. If sol_i arrives before a line has 90 bits, the partial line is dropped and the readback outputs stay as they were.
- R8: Cycles with in_valid low are ignored, so gaps may occur anywhere inside a line. Beats that arrive after a line completes and before the next sol_i are also ignored.
- R9: in_ready is held high at all times. The block accepts a beat in every cycle where in_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | One-cycle clear command for the readback state |
| sol_i | input | 1 | Start-of-line pulse |
| in_valid | input | 1 | Input beat valid |
| in_bit | input | 1 | Framed bit value |
| in_ready | output | 1 | Always 1; the block never stalls |
| slots_o | output | 72 | Nine data bytes, slot k at bits 8k+7:8k |
| crc_o | output | 8 | Computed check value |
| crc_ok_o | output | 1 | Computed check equals the received check byte |
| avail_o | output | 1 | A complete line has been decoded |

## Verification
The bench walks a single 1 through all 90 framed positions. A wrong sync offset, a reversed bit order or a slot off by one shows up as a bit in the wrong slot. A check that skips the sync bits gives a wrong crc_o for sync positions. It also sends lines that carry a correct check byte, so a flipped compare would leave crc_ok_o at 0.

Further cases:
- A line cut short by a new sol_i: a design that commits or counts on would corrupt the stored result.
- Stray beats after a line ends: a design that keeps counting would overwrite the result.
- Gapped valid: a design that counts every cycle would misplace bits.
- A clear in the same cycle as the final bit: a design that lets completion win would show a nonzero result.

// File: rtl/tc_deframe_pkg.sv
package tc_deframe_pkg;
  localparam int unsigned GROUPS     = 9;
  localparam int unsigned GROUP_BITS = 10;
  localparam int unsigned SYNC_BITS  = 2;
  localparam int unsigned CRC_W      = 8;
  localparam int unsigned DATA_W     = GROUP_BITS - SYNC_BITS;
  localparam int unsigned SLOT_BITS  = GROUPS * DATA_W;
  localparam int unsigned GRP_W      = $clog2(GROUPS);
  localparam int unsigned OFF_W      = $clog2(GROUP_BITS);
endpackage

// File: rtl/tc_pos_track.sv
module tc_pos_track #(
  parameter int unsigned GROUPS     = 9,
  parameter int unsigned GROUP_BITS = 10,
  localparam int unsigned GRP_W     = $clog2(GROUPS),
  localparam int unsigned OFF_W     = $clog2(GROUP_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sol,
  input  logic             in_valid,
  output logic             take,
  output logic             last_bit,
  output logic [GRP_W-1:0] cur_grp,
  output logic [OFF_W-1:0] cur_off
);
  logic             active_q;
  logic [GRP_W-1:0] grp_q;
  logic [OFF_W-1:0] off_q;
  logic             grp_end;

  assign cur_grp  = sol ? '0 : grp_q;
  assign cur_off  = sol ? '0 : off_q;
  assign take     = in_valid && (sol || active_q);
  assign grp_end  = (cur_off == OFF_W'(GROUP_BITS - 1));
  assign last_bit = take && grp_end && (cur_grp == GRP_W'(GROUPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      grp_q    <= '0;
      off_q    <= '0;
    end else if (take) begin
      if (last_bit) begin
        active_q <= 1'b0;
        grp_q    <= '0;
        off_q    <= '0;
      end else begin
        active_q <= 1'b1;
        if (grp_end) begin
          off_q <= '0;
          grp_q <= cur_grp + 1'b1;
        end else begin
          off_q <= cur_off + 1'b1;
          grp_q <= cur_grp;
        end
      end
    end else if (sol) begin
      active_q <= 1'b1;
      grp_q    <= '0;
      off_q    <= '0;
    end
  end
endmodule

// File: rtl/tc_slot_packer.sv
module tc_slot_packer #(
  parameter int unsigned GROUPS     = 9,
  parameter int unsigned GROUP_BITS = 10,
  parameter int unsigned SYNC_BITS  = 2,
  localparam int unsigned DATA_W    = GROUP_BITS - SYNC_BITS,
  localparam int unsigned SLOT_BITS = GROUPS * DATA_W,
  localparam int unsigned GRP_W     = $clog2(GROUPS),
  localparam int unsigned OFF_W     = $clog2(GROUP_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 in_bit,
  input  logic [GRP_W-1:0]     cur_grp,
  input  logic [OFF_W-1:0]     cur_off,
  output logic [SLOT_BITS-1:0] shadow_nxt
);
  logic [SLOT_BITS-1:0] shadow_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_slot
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic hit;
      assign hit = take && (cur_grp == GRP_W'(g)) && (cur_off == OFF_W'(b + SYNC_BITS));
      assign shadow_nxt[g*DATA_W + b] = hit ? in_bit : shadow_q[g*DATA_W + b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_nxt;
  end
endmodule

// File: rtl/tc_check_lfsr.sv
module tc_check_lfsr #(
  parameter int unsigned CRC_W      = 8,
  parameter int unsigned GROUPS     = 9,
  parameter int unsigned GROUP_BITS = 10,
  parameter int unsigned SYNC_BITS  = 2,
  localparam int unsigned GRP_W     = $clog2(GROUPS),
  localparam int unsigned OFF_W     = $clog2(GROUP_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sol,
  input  logic             take,
  input  logic             in_bit,
  input  logic [GRP_W-1:0] cur_grp,
  input  logic [OFF_W-1:0] cur_off,
  output logic [CRC_W-1:0] crc_q
);
  logic             covered;
  logic [CRC_W-1:0] base;

  // the check group's data bits are excluded; its sync bits are included
  assign covered = !((cur_grp == GRP_W'(GROUPS - 1)) && (cur_off >= OFF_W'(SYNC_BITS)));
  assign base    = sol ? '0 : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crc_q <= '0;
    else if (take && covered)  crc_q <= {base[CRC_W-2:0], base[CRC_W-1] ^ in_bit};
    else if (sol)              crc_q <= '0;
  end
endmodule

// File: rtl/tc_line_deframer.sv
module tc_line_deframer
  import tc_deframe_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 sol_i,
  input  logic                 in_valid,
  input  logic                 in_bit,
  output logic                 in_ready,
  output logic [SLOT_BITS-1:0] slots_o,
  output logic [CRC_W-1:0]     crc_o,
  output logic                 crc_ok_o,
  output logic                 avail_o
);
  logic                 take;
  logic                 line_done;
  logic [GRP_W-1:0]     cur_grp;
  logic [OFF_W-1:0]     cur_off;
  logic [SLOT_BITS-1:0] shadow_nxt;
  logic [CRC_W-1:0]     crc_run;

  assign in_ready = 1'b1;

  tc_pos_track #(.GROUPS(GROUPS), .GROUP_BITS(GROUP_BITS)) u_pos (
    .clk(clk), .rst_n(rst_n), .sol(sol_i), .in_valid(in_valid),
    .take(take), .last_bit(line_done), .cur_grp(cur_grp), .cur_off(cur_off)
  );

  tc_slot_packer #(.GROUPS(GROUPS), .GROUP_BITS(GROUP_BITS), .SYNC_BITS(SYNC_BITS)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .in_bit(in_bit),
    .cur_grp(cur_grp), .cur_off(cur_off), .shadow_nxt(shadow_nxt)
  );

  tc_check_lfsr #(.CRC_W(CRC_W), .GROUPS(GROUPS), .GROUP_BITS(GROUP_BITS),
                  .SYNC_BITS(SYNC_BITS)) u_crc (
    .clk(clk), .rst_n(rst_n), .sol(sol_i), .take(take), .in_bit(in_bit),
    .cur_grp(cur_grp), .cur_off(cur_off), .crc_q(crc_run)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_o  <= '0;
      crc_o    <= '0;
      crc_ok_o <= 1'b0;
      avail_o  <= 1'b0;
    end else if (clr_i) begin
      slots_o  <= '0;
      crc_o    <= '0;
      crc_ok_o <= 1'b0;
      avail_o  <= 1'b0;
    end else if (line_done) begin
      slots_o  <= shadow_nxt;
      crc_o    <= crc_run;
      crc_ok_o <= (crc_run == shadow_nxt[SLOT_BITS-1 -: CRC_W]);
      avail_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/tc_deframer_chk.sv
module tc_deframer_chk
  import tc_deframe_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr_i,
  input logic                 line_done,
  input logic [GRP_W-1:0]     cur_grp,
  input logic [OFF_W-1:0]     cur_off,
  input logic [SLOT_BITS-1:0] slots_o,
  input logic [CRC_W-1:0]     crc_o,
  input logic                 crc_ok_o,
  input logic                 avail_o
);
  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!avail_o && !crc_ok_o && slots_o == '0 && crc_o == '0));

  a_r4_hold_between_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_done && !clr_i) |=> ($stable(slots_o) && $stable(crc_o) && $stable(crc_ok_o)));

  a_r4_avail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_o && !clr_i) |=> avail_o);

  a_r4_set_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !clr_i) |=> avail_o);

  a_r3_ok_matches: assert property (@(posedge clk) disable iff (!rst_n)
    avail_o |-> (crc_ok_o == (crc_o == slots_o[SLOT_BITS-1 -: CRC_W])));

  a_r3_ok_needs_avail: assert property (@(posedge clk) disable iff (!rst_n)
    !avail_o |-> !crc_ok_o);

  a_r1_position_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_off <= OFF_W'(GROUP_BITS - 1)) && (cur_grp <= GRP_W'(GROUPS - 1)));
endmodule

bind tc_line_deframer tc_deframer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .line_done(line_done),
  .cur_grp(cur_grp), .cur_off(cur_off), .slots_o(slots_o), .crc_o(crc_o),
  .crc_ok_o(crc_ok_o), .avail_o(avail_o)
);

// File: tb/sim_tc_line_deframer.sv
`timescale 1ns/1ps
module sim_tc_line_deframer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0, sol_i = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic        in_ready, crc_ok_o, avail_o;
  logic [71:0] slots_o;
  logic [7:0]  crc_o;
  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  tc_line_deframer u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .sol_i(sol_i), .in_valid(in_valid),
    .in_bit(in_bit), .in_ready(in_ready), .slots_o(slots_o), .crc_o(crc_o),
    .crc_ok_o(crc_ok_o), .avail_o(avail_o)
  );

  function automatic logic [71:0] exp_slots(input logic [89:0] b);
    logic [71:0] s;
    for (int k = 0; k < 9; k++)
      for (int j = 0; j < 8; j++) s[k*8+j] = b[k*10+2+j];
    return s;
  endfunction

  function automatic logic [7:0] exp_crc(input logic [89:0] b);
    logic [7:0] c = '0;
    for (int i = 0; i < 82; i++) c[(81-i)%8] ^= b[i];
    return c;
  endfunction

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [89:0] b, input int n, input bit with_sol,
                      input int gap, input bit clr_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sol_i = with_sol && (i == 0); in_valid = 1'b1; in_bit = b[i];
      clr_i = clr_last && (i == n-1);
      if (gap > 0 && (i % gap) == 0) begin
        @(negedge clk);
        sol_i = 1'b0; in_valid = 1'b0; in_bit = ~in_bit; clr_i = 1'b0;
      end
    end
    @(negedge clk);
    sol_i = 1'b0; in_valid = 1'b0; clr_i = 1'b0;
  endtask

  task automatic expect_line(input logic [89:0] b, input string tag);
    logic [71:0] s = exp_slots(b);
    logic [7:0]  c = exp_crc(b);
    chk({"R1 slots ", tag}, slots_o, s);
    chk({"R2 crc ", tag}, {64'd0, crc_o}, {64'd0, c});
    chk({"R3 ok ", tag}, {71'd0, crc_ok_o}, {71'd0, (c == s[71:64])});
    chk({"R4 avail ", tag}, {71'd0, avail_o}, 72'd1);
  endtask

  initial begin
    logic [89:0] ln, keep;
    logic [31:0] seed = 32'h1234_5678;
    logic [71:0] snap_s;
    logic [7:0]  snap_c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset slots", slots_o, '0);
    chk("R5 reset crc", {64'd0, crc_o}, '0);
    chk("R5 reset flags", {70'd0, avail_o, crc_ok_o}, '0);
    chk("R9 ready", {71'd0, in_ready}, 72'd1);

    // R1/R2: walking one through every framed position, sync bits included
    for (int p = 0; p < 90; p++) begin
      ln = 90'd1 << p;
      send(ln, 90, 1'b1, 0, 1'b0);
      expect_line(ln, "walk");
    end

    // R8: pseudo-random lines with in_valid gaps
    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < 90; i++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        ln[i] = seed[17];
      end
      send(ln, 90, 1'b1, (t % 4) + 1, 1'b0);
      expect_line(ln, "R8 gapped");
    end

    // R3: lines whose check byte matches the computed value
    for (int t = 0; t < 8; t++) begin
      for (int i = 0; i < 90; i++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        ln[i] = seed[21];
      end
      for (int j = 0; j < 8; j++) ln[82+j] = exp_crc(ln)[j];
      send(ln, 90, 1'b1, 0, 1'b0);
      expect_line(ln, "R3 match");
      chk("R3 ok high", {71'd0, crc_ok_o}, 72'd1);
    end

    // R7: aborted partial line leaves readback intact, next line decodes
    keep = ln; snap_s = slots_o; snap_c = crc_o;
    send(~ln, 45, 1'b1, 0, 1'b0);
    chk("R7 partial slots", slots_o, snap_s);
    chk("R7 partial crc", {64'd0, crc_o}, {64'd0, snap_c});
    ln = {45'h0AAA_5555_1234, 45'h1F0F_0F0F_0F0F};
    send(ln, 90, 1'b1, 0, 1'b0);
    expect_line(ln, "R7 after abort");

    // R8: stray beats after completion without sol are ignored
    send(~keep, 30, 1'b0, 0, 1'b0);
    expect_line(ln, "R8 stray");

    // R6: clear while idle
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    chk("R6 clear slots", slots_o, '0);
    chk("R6 clear flags", {64'd0, crc_o}, '0);
    chk("R6 clear avail", {70'd0, avail_o, crc_ok_o}, '0);

    // R6: clear coinciding with line completion wins
    send(keep, 90, 1'b1, 0, 1'b1);
    chk("R6 clr wins slots", slots_o, '0);
    chk("R6 clr wins avail", {70'd0, avail_o, crc_ok_o}, '0);
    send(keep, 90, 1'b1, 2, 1'b0);
    expect_line(keep, "R6 after clear");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule